// File: doc/BRIEF.md
# I2C Master Acknowledge and STOP Sequencer

This block is the piece of an I2C master that closes out a byte and closes out a transfer. After a byte has been received, software strobes `ack_start` with `ack_value` chosen: the block pulls SCL low, presents the acknowledge bit on SDA, and runs one clock pulse on SCL. At the end of a transfer, software strobes `stop_start` and the block walks SDA low, releases SCL, and then releases SDA while SCL is high, which forms a STOP condition on the bus.

Both sequences are paced by a down-counting baud generator. It reloads from `reload_val`, so one baud period lasts `reload_val + 1` system clocks. The block never trusts its own drive. It waits for the sampled line levels before it moves on, so a slave that stretches SCL, or a slow SDA line, simply lengthens the phase concerned. Both line outputs are drive-low enables for open-drain pads. While a sequence runs, a CPU write to the transmit buffer is refused and flagged as a write collision. `irq_flag` marks the end of each sequence, and `stop_seen` marks that a STOP was seen on the bus.

Top module: `i2c_ackstop_seq`

## Requirements
- R1: On `ack_start` while idle, from the next cycle `scl_pull_low` is 1 and `sda_pull_low` equals the inverse of `ack_value` (0 gives ACK with SDA driven low, 1 gives NACK with SDA released), and `ack_active` is 1.
- R2: In an acknowledge, SCL stays driven low for reload+1 cycles and is then released for reload+1 cycles when no slave stretches the clock.
- R3: While SCL is released by the block but sampled low, the baud counter holds. Each such cycle lengthens the released phase by exactly one cycle.
- R4: At the end of an acknowledge, `scl_pull_low` is 1 again, `ack_active` is 0, SDA is released and `irq_flag` is 1.
- R5: On `stop_start` while idle, from the next cycle both lines are driven low and `stop_active` is 1. SCL is released reload+1 cycles after the cycle in which SDA is first sampled low, so SCL is low for reload+2+d cycles when SDA reads high for d extra cycles.
- R6: In a STOP, SDA stays driven low for reload+1 cycles after SCL is released. The released phase follows the same hold rule as R3.
- R7: `stop_seen` is set only after SDA and SCL are both sampled high, once SDA has been released. Exactly reload+1 cycles later, `stop_active` is 0 and `irq_flag` is 1, with both lines released.
- R8: A `buf_wr` while idle loads `buf_wdata` into `buf_q` on the next cycle. A `buf_wr` while either sequence is active leaves `buf_q` unchanged and sets `wcol_flag`.
- R9: `irq_flag` and `wcol_flag` stay set until `irq_clr` or `wcol_clr` respectively; a set event wins over a clear in the same cycle. `stop_seen` is cleared when a new sequence starts.
- R10: A start strobe that arrives while a sequence is active has no effect. If both strobes arrive together while idle, the acknowledge starts and the STOP is dropped.
- R11: After reset both lines are released, and `ack_active`, `stop_active`, `stop_seen`, `irq_flag`, `wcol_flag` and `buf_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reload_val | input | RELOAD_W | Baud reload value; one period is reload_val+1 clocks |
| ack_start | input | 1 | Strobe that starts an acknowledge sequence |
| ack_value | input | 1 | Acknowledge bit to send (0 ACK, 1 NACK) |
| stop_start | input | 1 | Strobe that starts a STOP sequence |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_pull_low | output | 1 | Drive SCL pad low when 1 |
| sda_pull_low | output | 1 | Drive SDA pad low when 1 |
| buf_wr | input | 1 | CPU write strobe for the transmit buffer |
| buf_wdata | input | DATA_W | CPU write data |
| irq_clr | input | 1 | Clears the interrupt flag |
| wcol_clr | input | 1 | Clears the write-collision flag |
| buf_q | output | DATA_W | Transmit buffer contents |
| ack_active | output | 1 | Acknowledge sequence in progress |
| stop_active | output | 1 | STOP sequence in progress |
| stop_seen | output | 1 | STOP detected on the bus |
| irq_flag | output | 1 | Sequence-complete interrupt flag |
| wcol_flag | output | 1 | Write-collision flag |

## Verification
The bench keeps the default widths, a 7-bit reload and an 8-bit buffer, and drives `reload_val` with 0, 3, 5 and 127. The value 0 gives one-cycle phases, where a reload and a timeout fall on the same edge. The value 127 is the largest reload and confirms that the period stays reload+1 at full counter width. The bench models the open-drain lines itself. It can stretch SCL, hold SDA high, or hold SDA low, which makes the hold rule and the wait-for-level steps observable as exact cycle counts at the ports.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_ACK_LO  = 3'd1,
    SQ_ACK_HI  = 3'd2,
    SQ_STP_ARM = 3'd3,
    SQ_STP_LO  = 3'd4,
    SQ_STP_HI  = 3'd5,
    SQ_STP_REL = 3'd6,
    SQ_STP_END = 3'd7
  } seq_state_e;

  typedef struct packed {
    logic scl_low;   // block drives SCL low
    logic sda_low;   // block drives SDA low
    logic counting;  // baud counter runs in this state
    logic scl_free;  // block has let go of SCL (hold rule applies)
  } seq_drive_t;

  // Line drive and counter control implied by a state.
  function automatic seq_drive_t decode_state(input seq_state_e st,
                                              input logic ack_bit,
                                              input logic park);
    seq_drive_t d;
    d = '0;
    unique case (st)
      SQ_IDLE:    d.scl_low = park;
      SQ_ACK_LO:  begin d.scl_low = 1'b1; d.sda_low = ~ack_bit; d.counting = 1'b1; end
      SQ_ACK_HI:  begin d.sda_low = ~ack_bit; d.counting = 1'b1; d.scl_free = 1'b1; end
      SQ_STP_ARM: begin d.scl_low = 1'b1; d.sda_low = 1'b1; end
      SQ_STP_LO:  begin d.scl_low = 1'b1; d.sda_low = 1'b1; d.counting = 1'b1; end
      SQ_STP_HI:  begin d.sda_low = 1'b1; d.counting = 1'b1; d.scl_free = 1'b1; end
      SQ_STP_REL: d = '0;
      SQ_STP_END: begin d.counting = 1'b1; d.scl_free = 1'b1; end
      default:    d = '0;
    endcase
    return d;
  endfunction

  // Down-count with automatic reload on rollover.
  function automatic logic [15:0] baud_next(input logic [15:0] cnt,
                                            input logic [15:0] reload);
    return (cnt == 16'd0) ? reload : cnt - 16'd1;
  endfunction

  // Length of one baud period in system clocks.
  function automatic int unsigned baud_cycles(input int unsigned reload);
    return reload + 1;
  endfunction

endpackage

// File: rtl/i2c_baud_ctr.sv
module i2c_baud_ctr
  import i2c_seq_pkg::*;
#(
  parameter int RELOAD_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                restart,
  input  logic                run,
  input  logic                hold,
  output logic [RELOAD_W-1:0] cnt,
  output logic                tick
);
  localparam int PADW = 16 - RELOAD_W;

  logic [15:0] nxt_wide;
  logic        advance;

  assign advance  = run & ~hold & ~restart;
  assign nxt_wide = baud_next({{PADW{1'b0}}, cnt}, {{PADW{1'b0}}, reload});
  assign tick     = advance & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= reload;
    else if (advance) cnt <= nxt_wide[RELOAD_W-1:0];
  end
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ack_req,
  input  logic ack_bit_in,
  input  logic stop_req,
  input  logic scl_in,
  input  logic sda_in,
  input  logic tick,
  output logic ack_go,
  output logic stop_go,
  output logic stop_hit,
  output logic seq_done,
  output logic cnt_restart,
  output logic cnt_run,
  output logic cnt_hold,
  output logic scl_low,
  output logic sda_low,
  output logic ack_busy,
  output logic stop_busy
);
  seq_state_e state, state_nxt;
  logic       ack_bit, park, park_nxt;
  seq_drive_t drv;

  assign drv = decode_state(state, ack_bit, park);

  assign ack_go  = ack_req & (state == SQ_IDLE);
  assign stop_go = stop_req & ~ack_req & (state == SQ_IDLE);

  always_comb begin
    state_nxt   = state;
    park_nxt    = park;
    cnt_restart = 1'b0;
    stop_hit    = 1'b0;
    seq_done    = 1'b0;
    unique case (state)
      SQ_IDLE: begin
        if (ack_go) begin
          state_nxt   = SQ_ACK_LO;
          cnt_restart = 1'b1;
        end else if (stop_go) begin
          state_nxt = SQ_STP_ARM;
        end
      end
      SQ_ACK_LO:  if (tick) state_nxt = SQ_ACK_HI;
      SQ_ACK_HI: begin
        if (tick) begin
          state_nxt = SQ_IDLE;
          park_nxt  = 1'b1;
          seq_done  = 1'b1;
        end
      end
      SQ_STP_ARM: begin
        if (!sda_in) begin
          state_nxt   = SQ_STP_LO;
          cnt_restart = 1'b1;
        end
      end
      SQ_STP_LO:  if (tick) state_nxt = SQ_STP_HI;
      SQ_STP_HI:  if (tick) state_nxt = SQ_STP_REL;
      SQ_STP_REL: begin
        if (scl_in && sda_in) begin
          state_nxt   = SQ_STP_END;
          cnt_restart = 1'b1;
          stop_hit    = 1'b1;
        end
      end
      SQ_STP_END: begin
        if (tick) begin
          state_nxt = SQ_IDLE;
          park_nxt  = 1'b0;
          seq_done  = 1'b1;
        end
      end
      default: state_nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      ack_bit <= 1'b1;
      park    <= 1'b0;
    end else begin
      state <= state_nxt;
      park  <= park_nxt;
      if (ack_go) ack_bit <= ack_bit_in;
    end
  end

  assign cnt_run   = drv.counting;
  assign cnt_hold  = drv.scl_free & ~scl_in;
  assign scl_low   = drv.scl_low;
  assign sda_low   = drv.sda_low;
  assign ack_busy  = (state == SQ_ACK_LO) | (state == SQ_ACK_HI);
  assign stop_busy = (state != SQ_IDLE) & ~ack_busy;
endmodule

// File: rtl/i2c_seq_flags.sv
module i2c_seq_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_start,
  input  logic              seq_done,
  input  logic              stop_hit,
  input  logic              busy,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_wdata,
  input  logic              irq_clr,
  input  logic              wcol_clr,
  output logic              wr_collide,
  output logic [DATA_W-1:0] buf_q,
  output logic              irq_flag,
  output logic              wcol_flag,
  output logic              stop_seen
);
  assign wr_collide = buf_wr & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q     <= '0;
      irq_flag  <= 1'b0;
      wcol_flag <= 1'b0;
      stop_seen <= 1'b0;
    end else begin
      if (buf_wr && !busy) buf_q <= buf_wdata;

      if (seq_done)     irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;

      if (wr_collide)    wcol_flag <= 1'b1;
      else if (wcol_clr) wcol_flag <= 1'b0;

      if (stop_hit)       stop_seen <= 1'b1;
      else if (seq_start) stop_seen <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_ackstop_seq.sv
module i2c_ackstop_seq #(
  parameter int RELOAD_W = 7,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RELOAD_W-1:0] reload_val,
  input  logic                ack_start,
  input  logic                ack_value,
  input  logic                stop_start,
  input  logic                scl_in,
  input  logic                sda_in,
  output logic                scl_pull_low,
  output logic                sda_pull_low,
  input  logic                buf_wr,
  input  logic [DATA_W-1:0]   buf_wdata,
  input  logic                irq_clr,
  input  logic                wcol_clr,
  output logic [DATA_W-1:0]   buf_q,
  output logic                ack_active,
  output logic                stop_active,
  output logic                stop_seen,
  output logic                irq_flag,
  output logic                wcol_flag
);
  logic                ack_go, stop_go, stop_hit, seq_done;
  logic                baud_restart, baud_run, baud_hold, baud_tick;
  logic [RELOAD_W-1:0] baud_cnt;
  logic                seq_busy, wr_collide;

  i2c_baud_ctr #(.RELOAD_W(RELOAD_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (reload_val),
    .restart (baud_restart),
    .run     (baud_run),
    .hold    (baud_hold),
    .cnt     (baud_cnt),
    .tick    (baud_tick)
  );

  i2c_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_req     (ack_start),
    .ack_bit_in  (ack_value),
    .stop_req    (stop_start),
    .scl_in      (scl_in),
    .sda_in      (sda_in),
    .tick        (baud_tick),
    .ack_go      (ack_go),
    .stop_go     (stop_go),
    .stop_hit    (stop_hit),
    .seq_done    (seq_done),
    .cnt_restart (baud_restart),
    .cnt_run     (baud_run),
    .cnt_hold    (baud_hold),
    .scl_low     (scl_pull_low),
    .sda_low     (sda_pull_low),
    .ack_busy    (ack_active),
    .stop_busy   (stop_active)
  );

  assign seq_busy = ack_active | stop_active;

  i2c_seq_flags #(.DATA_W(DATA_W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .seq_start  (ack_go | stop_go),
    .seq_done   (seq_done),
    .stop_hit   (stop_hit),
    .busy       (seq_busy),
    .buf_wr     (buf_wr),
    .buf_wdata  (buf_wdata),
    .irq_clr    (irq_clr),
    .wcol_clr   (wcol_clr),
    .wr_collide (wr_collide),
    .buf_q      (buf_q),
    .irq_flag   (irq_flag),
    .wcol_flag  (wcol_flag),
    .stop_seen  (stop_seen)
  );
endmodule

// File: rtl/i2c_ackstop_chk.sv
module i2c_ackstop_chk #(
  parameter int RELOAD_W = 7,
  parameter int DATA_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ack_go,
  input logic                ack_value,
  input logic                scl_in,
  input logic                sda_in,
  input logic                scl_pull_low,
  input logic                sda_pull_low,
  input logic                baud_hold,
  input logic                baud_run,
  input logic                baud_restart,
  input logic [RELOAD_W-1:0] baud_cnt,
  input logic                ack_active,
  input logic                stop_active,
  input logic                seq_busy,
  input logic                seq_done,
  input logic                buf_wr,
  input logic [DATA_W-1:0]   buf_q,
  input logic                stop_seen,
  input logic                irq_flag,
  input logic                wcol_flag
);
  assert_ack_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ack_go |=> (scl_pull_low && (sda_pull_low == !$past(ack_value))));

  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_run && baud_hold && !baud_restart) |=> $stable(baud_cnt));

  assert_ack_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_active) |-> (scl_pull_low && irq_flag && !stop_active));

  assert_stop_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_seen) |-> ($past(scl_in) && $past(sda_in)));

  assert_wcol_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && seq_busy) |=> (wcol_flag && $stable(buf_q)));

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(seq_done));

  assert_one_seq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_active, stop_active}));
endmodule

bind i2c_ackstop_seq i2c_ackstop_chk #(.RELOAD_W(RELOAD_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ack_go       (ack_go),
  .ack_value    (ack_value),
  .scl_in       (scl_in),
  .sda_in       (sda_in),
  .scl_pull_low (scl_pull_low),
  .sda_pull_low (sda_pull_low),
  .baud_hold    (baud_hold),
  .baud_run     (baud_run),
  .baud_restart (baud_restart),
  .baud_cnt     (baud_cnt),
  .ack_active   (ack_active),
  .stop_active  (stop_active),
  .seq_busy     (seq_busy),
  .seq_done     (seq_done),
  .buf_wr       (buf_wr),
  .buf_q        (buf_q),
  .stop_seen    (stop_seen),
  .irq_flag     (irq_flag),
  .wcol_flag    (wcol_flag)
);

// File: tb/i2c_ackstop_seq_tb.sv
module i2c_ackstop_seq_tb;
  localparam int RW = 7;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [RW-1:0] reload_val = '0;
  logic          ack_start = 1'b0, ack_value = 1'b0, stop_start = 1'b0;
  logic          scl_in, sda_in, scl_pull_low, sda_pull_low;
  logic          buf_wr = 1'b0;
  logic [DW-1:0] buf_wdata = '0;
  logic          irq_clr = 1'b0, wcol_clr = 1'b0;
  logic [DW-1:0] buf_q;
  logic          ack_active, stop_active, stop_seen, irq_flag, wcol_flag;

  logic stretch = 1'b0, sda_stuck_hi = 1'b0, ext_sda_low = 1'b0;
  int   n_checks = 0, n_errors = 0;
  bit   done = 1'b0;

  assign scl_in = !scl_pull_low && !stretch;
  assign sda_in = sda_stuck_hi ? 1'b1 : (!sda_pull_low && !ext_sda_low);

  always #2 clk = ~clk;

  i2c_ackstop_seq #(.RELOAD_W(RW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reload_val(reload_val),
    .ack_start(ack_start), .ack_value(ack_value), .stop_start(stop_start),
    .scl_in(scl_in), .sda_in(sda_in),
    .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .irq_clr(irq_clr), .wcol_clr(wcol_clr),
    .buf_q(buf_q), .ack_active(ack_active), .stop_active(stop_active),
    .stop_seen(stop_seen), .irq_flag(irq_flag), .wcol_flag(wcol_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_irq_clr();
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic wait_idle();
    int g = 0;
    while ((ack_active || stop_active) && g < 2000) begin g++; @(negedge clk); end
  endtask

  // R11
  task automatic t_reset();
    check(!scl_pull_low && !sda_pull_low, "R11 lines released", {scl_pull_low, sda_pull_low}, 0);
    check(!ack_active && !stop_active, "R11 idle", {ack_active, stop_active}, 0);
    check(!stop_seen && !irq_flag && !wcol_flag, "R11 flags", {stop_seen, irq_flag, wcol_flag}, 0);
    check(buf_q == 0, "R11 buffer", buf_q, 0);
  endtask

  // R1 R2 R3 R4
  task automatic t_ack(input int rl, input logic dbit, input int s);
    int cnt;
    reload_val = rl[RW-1:0];
    stretch = (s > 0);
    ack_value = dbit; ack_start = 1'b1;
    @(negedge clk); ack_start = 1'b0;
    check(scl_pull_low && (sda_pull_low == !dbit) && ack_active, "R1 ack drive",
          {scl_pull_low, sda_pull_low, ack_active}, {1'b1, !dbit, 1'b1});
    cnt = 0;
    while (scl_pull_low && cnt < 1000) begin cnt++; @(negedge clk); end
    check(cnt == rl + 1, "R2 ack low phase", cnt, rl + 1);
    cnt = 0;
    while (!scl_pull_low && cnt < 1000) begin
      cnt++;
      if (cnt == s + 1) stretch = 1'b0;
      @(negedge clk);
    end
    stretch = 1'b0;
    if (s > 0) check(cnt == rl + 1 + s, "R3 stretched high phase", cnt, rl + 1 + s);
    else       check(cnt == rl + 1, "R2 ack high phase", cnt, rl + 1);
    check(scl_pull_low && !ack_active && !sda_pull_low && irq_flag, "R4 ack end",
          {scl_pull_low, ack_active, sda_pull_low, irq_flag}, 4'b1001);
    pulse_irq_clr();
  endtask

  // R5 R6 R7
  task automatic t_stop(input int rl, input int d, input int w);
    int cnt, expw;
    reload_val = rl[RW-1:0];
    sda_stuck_hi = (d > 0);
    stop_start = 1'b1;
    @(negedge clk); stop_start = 1'b0;
    check(scl_pull_low && sda_pull_low && stop_active, "R5 stop drive",
          {scl_pull_low, sda_pull_low, stop_active}, 3'b111);
    cnt = 0;
    while (scl_pull_low && cnt < 1000) begin
      cnt++;
      if (cnt == d + 1) sda_stuck_hi = 1'b0;
      @(negedge clk);
    end
    sda_stuck_hi = 1'b0;
    check(cnt == rl + 2 + d, "R5 scl low in stop", cnt, rl + 2 + d);
    ext_sda_low = (w > 0);
    cnt = 0;
    while (sda_pull_low && cnt < 1000) begin cnt++; @(negedge clk); end
    check(cnt == rl + 1, "R6 sda low after scl release", cnt, rl + 1);
    cnt = 0;
    while (!stop_seen && cnt < 1000) begin
      cnt++;
      if (cnt == w) ext_sda_low = 1'b0;
      @(negedge clk);
    end
    ext_sda_low = 1'b0;
    expw = (w > 1) ? w : 1;
    check(cnt == expw, "R7 stop_seen waits for lines high", cnt, expw);
    cnt = 0;
    while (!irq_flag && cnt < 1000) begin cnt++; @(negedge clk); end
    check(cnt == rl + 1, "R7 stop end delay", cnt, rl + 1);
    check(!stop_active && !scl_pull_low && !sda_pull_low && stop_seen, "R7 stop end state",
          {stop_active, scl_pull_low, sda_pull_low, stop_seen}, 4'b0001);
    pulse_irq_clr();
  endtask

  // R8 R9
  task automatic t_wcol();
    buf_wr = 1'b1; buf_wdata = 8'hA5;
    @(negedge clk); buf_wr = 1'b0;
    check(buf_q == 8'hA5 && !wcol_flag, "R8 idle write", buf_q, 8'hA5);
    reload_val = 7'd5;
    ack_value = 1'b0; ack_start = 1'b1;
    @(negedge clk); ack_start = 1'b0;
    buf_wr = 1'b1; buf_wdata = 8'h3C;
    @(negedge clk); buf_wr = 1'b0;
    check(buf_q == 8'hA5 && wcol_flag, "R8 write during ack", buf_q, 8'hA5);
    wait_idle();
    tick_n(3);
    check(wcol_flag && irq_flag, "R9 flags sticky", {wcol_flag, irq_flag}, 3);
    wcol_clr = 1'b1; @(negedge clk); wcol_clr = 1'b0;
    check(!wcol_flag && irq_flag, "R9 wcol clear only", {wcol_flag, irq_flag}, 1);
    pulse_irq_clr();
    check(!irq_flag, "R9 irq clear", irq_flag, 0);
    stop_start = 1'b1; @(negedge clk); stop_start = 1'b0;
    tick_n(2);
    buf_wr = 1'b1; buf_wdata = 8'h77;
    @(negedge clk); buf_wr = 1'b0;
    check(buf_q == 8'hA5 && wcol_flag, "R8 write during stop", buf_q, 8'hA5);
    wait_idle();
    wcol_clr = 1'b1; @(negedge clk); wcol_clr = 1'b0;
    check(stop_seen, "R9 stop_seen held at end", stop_seen, 1);
    ack_value = 1'b1; ack_start = 1'b1;
    @(negedge clk); ack_start = 1'b0;
    check(!stop_seen, "R9 stop_seen cleared on new sequence", stop_seen, 0);
    wait_idle();
    pulse_irq_clr();
  endtask

  // R10
  task automatic t_ignore();
    int cnt;
    reload_val = 7'd4;
    ack_value = 1'b0; ack_start = 1'b1;
    @(negedge clk); ack_start = 1'b0;
    stop_start = 1'b1; ack_start = 1'b1; ack_value = 1'b1;
    @(negedge clk); stop_start = 1'b0; ack_start = 1'b0;
    check(ack_active && !stop_active && sda_pull_low, "R10 strobe ignored while active",
          {ack_active, stop_active, sda_pull_low}, 3'b101);
    cnt = 2;
    while (scl_pull_low && cnt < 1000) begin cnt++; @(negedge clk); end
    check(cnt == 6, "R10 ack timing unchanged", cnt - 1, 5);
    wait_idle();
    pulse_irq_clr();
    ack_value = 1'b1; ack_start = 1'b1; stop_start = 1'b1;
    @(negedge clk); ack_start = 1'b0; stop_start = 1'b0;
    check(ack_active && !stop_active && !sda_pull_low, "R10 ack wins tie",
          {ack_active, stop_active, sda_pull_low}, 3'b100);
    wait_idle();
    tick_n(2);
    check(!stop_active && !ack_active, "R10 dropped stop stays dropped", stop_active, 0);
    pulse_irq_clr();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    tick_n(3);
    t_reset();
    rst_n = 1'b1;
    tick_n(2);
    t_reset();
    t_ack(3, 1'b0, 0);
    t_ack(0, 1'b1, 0);
    t_ack(3, 1'b0, 4);
    t_ack(127, 1'b1, 0);
    t_stop(3, 0, 0);
    t_stop(0, 0, 0);
    t_stop(3, 2, 3);
    t_stop(127, 0, 0);
    t_wcol();
    t_ignore();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule